// File: doc/BRIEF.md
# Timestamp LRU Victim Selector

This block holds a last-use time for each way of each set in a set-associative cache, and it names the way to evict from a set. The enclosing cache controller uses it in three ways. When a line is used, the controller presents a touch with a set, a way and a time value. When it needs room in a set, it presents that set on the query port and receives the way with the oldest stored time. It can also read back the stored time of any entry.

The controller supplies the time base, for example from a free-running cycle counter. The time values it presents must never decrease, otherwise the recency ordering is lost. The number of sets is derived from the parameters: capacity in bytes divided by line size, divided by the number of ways.

A touch is a single-cycle strobe and is never back-pressured: every cycle with `touch_valid` high is taken. The query and readback ports are purely combinational over the stored times, and a touch becomes visible on them after the next rising clock edge. Each index port is `$clog2(N+1)` bits wide for a count of N, so that an out-of-range code always exists. With the defaults this gives 4 sets (set bits 3) and 3 ways (way bits 2).

Top module: `lru_ts_victim_sel`

## Requirements
- R1: The set count is CAP_BYTES / LINE_BYTES / WAYS (4 with the defaults), and a touch set index at or above that count is out of range.
- R2: While `rst_n` is low, every stored time is cleared to zero and `err_flag` is cleared.
- R3: A touch with in-range set and way stores `touch_time` in that one entry at the next rising edge, and no other entry changes.
- R4: `victim_way` combinationally gives the way of the queried set whose stored time is the smallest.
- R5: When several ways share the smallest time, `victim_way` gives the lowest-numbered of them.
- R6: A touch whose way index is at or above WAYS, or whose set index is out of range, changes no stored entry.
- R7: Such an out-of-range touch sets `err_flag` at the next rising edge, and the flag stays set until reset, even across later legal touches.
- R8: `rd_time` combinationally shows the stored time of entry (`rd_set`, `rd_way`), and it reads zero when either index is out of range.
- R9: A query whose set index is out of range gives `victim_way` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_valid | input | 1 | Touch strobe, taken in every cycle it is high |
| touch_set | input | SET_W | Set index of the touch |
| touch_way | input | WAY_W | Way index of the touch |
| touch_time | input | TS_W | Time value to store |
| query_set | input | SET_W | Set in which a victim is sought |
| victim_way | output | WAY_W | Way holding the oldest time in the queried set |
| rd_set | input | SET_W | Readback set index |
| rd_way | input | WAY_W | Readback way index |
| rd_time | output | TS_W | Stored time at the readback address |
| err_flag | output | 1 | Sticky out-of-range touch indicator |

## Verification
The following properties are checked on every cycle:
- The chosen victim's time is no larger than that of any other way in the queried set, and no lower-numbered way holds an equal time.
- A legal touch shows up at its own readback address one cycle later.
- An illegal touch leaves the addressed readback value alone, and the error flag rises and stays set.
- Out-of-range reads and queries return zero.

The bench scenarios cover what those properties cannot see:
- The victim moving through a set as its ways are touched in turn.
- Separation between sets.
- The zero state after a second reset.
- A full sweep of every entry after each illegal touch, which shows that nothing anywhere was written.

// File: rtl/lru_ts_pkg.sv
package lru_ts_pkg;
  // index width that leaves at least one out-of-range code
  function automatic int idx_w(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lru_ts_guard.sv
module lru_ts_guard #(
  parameter int SETS  = 4,
  parameter int WAYS  = 3,
  parameter int SET_W = 3,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_valid,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  output logic             wr_en,
  output logic             err_flag
);
  logic in_range;
  logic err_q;

  assign in_range = (touch_set < SET_W'(SETS)) && (touch_way < WAY_W'(WAYS));
  assign wr_en    = touch_valid && in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (touch_valid && !in_range) begin
      err_q <= 1'b1;
    end
  end

  assign err_flag = err_q;
endmodule

// File: rtl/lru_ts_store.sv
module lru_ts_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 3,
  parameter int TS_W  = 32,
  parameter int SET_W = 3,
  parameter int WAY_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SET_W-1:0]     wr_set,
  input  logic [WAY_W-1:0]     wr_way,
  input  logic [TS_W-1:0]      wr_time,
  input  logic [SET_W-1:0]     q_set,
  output logic [WAYS*TS_W-1:0] q_row,
  input  logic [SET_W-1:0]     rd_set,
  input  logic [WAY_W-1:0]     rd_way,
  output logic [TS_W-1:0]      rd_time
);
  logic [TS_W-1:0] mem_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          mem_q[s][w] <= '0;
        end
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (wr_en && wr_set == SET_W'(s) && wr_way == WAY_W'(w)) begin
            mem_q[s][w] <= wr_time;
          end
        end
      end
    end
  end

  // whole row of the queried set; all zero when the set is out of range
  always_comb begin
    q_row = '0;
    for (int s = 0; s < SETS; s++) begin
      if (q_set == SET_W'(s)) begin
        for (int w = 0; w < WAYS; w++) begin
          q_row[w*TS_W +: TS_W] = mem_q[s][w];
        end
      end
    end
  end

  // single-entry readback; zero when either index is out of range
  always_comb begin
    rd_time = '0;
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        if (rd_set == SET_W'(s) && rd_way == WAY_W'(w)) begin
          rd_time = mem_q[s][w];
        end
      end
    end
  end
endmodule

// File: rtl/lru_ts_minfind.sv
module lru_ts_minfind #(
  parameter int WAYS  = 3,
  parameter int TS_W  = 32,
  parameter int WAY_W = 2
) (
  input  logic [WAYS*TS_W-1:0] row,
  output logic [WAY_W-1:0]     victim
);
  logic [TS_W-1:0]  cand_t [WAYS];
  logic [WAY_W-1:0] cand_w [WAYS];

  assign cand_t[0] = row[TS_W-1:0];
  assign cand_w[0] = '0;

  // linear chain: a later way wins only on a strictly smaller time
  for (genvar i = 1; i < WAYS; i++) begin : g_step
    logic take;
    assign take      = row[i*TS_W +: TS_W] < cand_t[i-1];
    assign cand_t[i] = take ? row[i*TS_W +: TS_W] : cand_t[i-1];
    assign cand_w[i] = take ? WAY_W'(i) : cand_w[i-1];
  end

  assign victim = cand_w[WAYS-1];
endmodule

// File: rtl/lru_ts_victim_sel.sv
module lru_ts_victim_sel #(
  parameter int CAP_BYTES  = 768,
  parameter int LINE_BYTES = 64,
  parameter int WAYS       = 3,
  parameter int TS_W       = 32,
  localparam int SETS      = CAP_BYTES / LINE_BYTES / WAYS,
  localparam int SET_W     = lru_ts_pkg::idx_w(SETS),
  localparam int WAY_W     = lru_ts_pkg::idx_w(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_valid,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [TS_W-1:0]  touch_time,
  input  logic [SET_W-1:0] query_set,
  output logic [WAY_W-1:0] victim_way,
  input  logic [SET_W-1:0] rd_set,
  input  logic [WAY_W-1:0] rd_way,
  output logic [TS_W-1:0]  rd_time,
  output logic             err_flag
);
  logic                 wr_en;
  logic [WAYS*TS_W-1:0] q_row;

  lru_ts_guard #(
    .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_guard (
    .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid),
    .touch_set(touch_set), .touch_way(touch_way),
    .wr_en(wr_en), .err_flag(err_flag)
  );

  lru_ts_store #(
    .SETS(SETS), .WAYS(WAYS), .TS_W(TS_W), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_set(touch_set), .wr_way(touch_way), .wr_time(touch_time),
    .q_set(query_set), .q_row(q_row),
    .rd_set(rd_set), .rd_way(rd_way), .rd_time(rd_time)
  );

  lru_ts_minfind #(
    .WAYS(WAYS), .TS_W(TS_W), .WAY_W(WAY_W)
  ) u_min (
    .row(q_row), .victim(victim_way)
  );
endmodule

// File: rtl/lru_ts_victim_sel_chk.sv
module lru_ts_victim_sel_chk #(
  parameter int SETS  = 4,
  parameter int WAYS  = 3,
  parameter int TS_W  = 32,
  parameter int SET_W = 3,
  parameter int WAY_W = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 touch_valid,
  input logic [SET_W-1:0]     touch_set,
  input logic [WAY_W-1:0]     touch_way,
  input logic [TS_W-1:0]      touch_time,
  input logic [SET_W-1:0]     query_set,
  input logic [WAY_W-1:0]     victim_way,
  input logic [SET_W-1:0]     rd_set,
  input logic [WAY_W-1:0]     rd_way,
  input logic [TS_W-1:0]      rd_time,
  input logic                 err_flag,
  input logic [WAYS*TS_W-1:0] q_row
);
  logic            legal;
  logic            min_ok;
  logic            tie_ok;
  logic [TS_W-1:0] vt;

  assign legal = (touch_set < SET_W'(SETS)) && (touch_way < WAY_W'(WAYS));

  // compare the chosen way against every way of the row
  always_comb begin
    vt     = '0;
    min_ok = victim_way < WAY_W'(WAYS);
    tie_ok = 1'b1;
    for (int w = 0; w < WAYS; w++) begin
      if (victim_way == WAY_W'(w)) vt = q_row[w*TS_W +: TS_W];
    end
    for (int w = 0; w < WAYS; w++) begin
      if (q_row[w*TS_W +: TS_W] < vt) min_ok = 1'b0;
      if (WAY_W'(w) < victim_way && q_row[w*TS_W +: TS_W] == vt) tie_ok = 1'b0;
    end
  end

  a_r4_victim_is_min: assert property (@(posedge clk) disable iff (!rst_n)
    min_ok);

  a_r5_tie_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    tie_ok);

  a_r3_touch_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_valid && legal) |=>
      ((rd_set == $past(touch_set) && rd_way == $past(touch_way))
        -> rd_time == $past(touch_time)));

  a_r6_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_valid && !legal) |=>
      ((rd_set == $past(rd_set) && rd_way == $past(rd_way))
        -> rd_time == $past(rd_time)));

  a_r7_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_valid && !legal) |=> err_flag);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r8_rd_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_set >= SET_W'(SETS) || rd_way >= WAY_W'(WAYS)) |-> rd_time == '0);

  a_r9_query_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (query_set >= SET_W'(SETS)) |-> victim_way == '0);
endmodule

bind lru_ts_victim_sel lru_ts_victim_sel_chk #(
  .SETS(SETS), .WAYS(WAYS), .TS_W(TS_W), .SET_W(SET_W), .WAY_W(WAY_W)
) u_chk (.*);

// File: tb/lru_ts_victim_sel_bench.sv
module lru_ts_victim_sel_bench;
  localparam int SETS = 4;
  localparam int WAYS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        touch_valid = 1'b0;
  logic [2:0]  touch_set = '0;
  logic [1:0]  touch_way = '0;
  logic [31:0] touch_time = '0;
  logic [2:0]  query_set = '0;
  logic [1:0]  victim_way;
  logic [2:0]  rd_set = '0;
  logic [1:0]  rd_way = '0;
  logic [31:0] rd_time;
  logic        err_flag;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] mdl [SETS][WAYS];

  always #10 clk = ~clk;

  lru_ts_victim_sel u_lru_ts_victim_sel (
    .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid),
    .touch_set(touch_set), .touch_way(touch_way), .touch_time(touch_time),
    .query_set(query_set), .victim_way(victim_way),
    .rd_set(rd_set), .rd_way(rd_way), .rd_time(rd_time),
    .err_flag(err_flag)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 touch, 1 victim check, 2 readback check
    logic [2:0]  set;
    logic [1:0]  way;
    logic [31:0] tm;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd0, 2'd0, 32'd10,  32'd0},   // R3
    '{2'd1, 3'd0, 2'd0, 32'd0,   32'd1},   // R5 ways 1,2 tie at 0
    '{2'd0, 3'd0, 2'd1, 32'd20,  32'd0},
    '{2'd1, 3'd0, 2'd0, 32'd0,   32'd2},   // R4
    '{2'd0, 3'd0, 2'd2, 32'd30,  32'd0},
    '{2'd1, 3'd0, 2'd0, 32'd0,   32'd0},   // R4
    '{2'd0, 3'd0, 2'd0, 32'd40,  32'd0},
    '{2'd1, 3'd0, 2'd0, 32'd0,   32'd1},   // R4
    '{2'd2, 3'd0, 2'd0, 32'd0,   32'd40},  // R8
    '{2'd0, 3'd1, 2'd2, 32'd50,  32'd0},
    '{2'd1, 3'd1, 2'd0, 32'd0,   32'd0},   // R5
    '{2'd2, 3'd0, 2'd2, 32'd0,   32'd30},  // R3 other set untouched
    '{2'd0, 3'd1, 2'd0, 32'd60,  32'd0},
    '{2'd1, 3'd1, 2'd0, 32'd0,   32'd1},   // R4
    '{2'd0, 3'd3, 2'd1, 32'd70,  32'd0},
    '{2'd1, 3'd3, 2'd0, 32'd0,   32'd0},   // R5
    '{2'd2, 3'd3, 2'd1, 32'd0,   32'd70},  // R8
    '{2'd0, 3'd2, 2'd0, 32'd100, 32'd0},
    '{2'd0, 3'd2, 2'd1, 32'd100, 32'd0},
    '{2'd0, 3'd2, 2'd2, 32'd100, 32'd0},
    '{2'd1, 3'd2, 2'd0, 32'd0,   32'd0},   // R5 three-way tie
    '{2'd0, 3'd2, 2'd0, 32'd110, 32'd0},
    '{2'd1, 3'd2, 2'd0, 32'd0,   32'd1},   // R5 two-way tie
    '{2'd2, 3'd1, 2'd1, 32'd0,   32'd0}    // R3 untouched entry stays 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_touch(input logic [2:0] s, input logic [1:0] w, input logic [31:0] t);
    @(negedge clk);
    touch_valid = 1'b1; touch_set = s; touch_way = w; touch_time = t;
    @(negedge clk);
    touch_valid = 1'b0;
    if (s < 3'(SETS) && w < 2'(WAYS)) mdl[s][w] = t;
  endtask

  task automatic see_victim(input string req, input logic [2:0] s, input logic [1:0] exp);
    @(negedge clk);
    query_set = s;
    #2;
    chk(req, 32'(victim_way), 32'(exp));
  endtask

  task automatic see_read(input string req, input logic [2:0] s, input logic [1:0] w, input logic [31:0] exp);
    @(negedge clk);
    rd_set = s; rd_way = w;
    #2;
    chk(req, rd_time, exp);
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        see_read(req, 3'(s), 2'(w), mdl[s][w]);
      end
    end
  endtask

  task automatic clear_mdl();
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) mdl[s][w] = '0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_mdl();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: state after reset
    chk("R2 err", 32'(err_flag), 0);
    sweep("R2 entries");
    see_victim("R2 victim", 3'd1, 2'd0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: do_touch(VEC[i].set, VEC[i].way, VEC[i].tm);
        2'd1: see_victim("R4/R5 victim", VEC[i].set, VEC[i].exp[1:0]);
        default: see_read("R3/R8 readback", VEC[i].set, VEC[i].way, VEC[i].exp);
      endcase
    end

    // R6/R7: way index out of range
    do_touch(3'd0, 2'd3, 32'd999);
    chk("R7 err raise", 32'(err_flag), 1);
    sweep("R6 bad way");
    see_victim("R6 victim kept", 3'd0, 2'd1);

    // R1/R6: set index 4 equals the set count and is out of range
    do_touch(3'd4, 2'd0, 32'd777);
    sweep("R1 set 4 stores nothing");
    do_touch(3'd5, 2'd1, 32'd778);
    sweep("R6 bad set");

    // R7 sticky across a legal touch
    do_touch(3'd0, 2'd1, 32'd120);
    chk("R7 sticky", 32'(err_flag), 1);
    see_victim("R4 after legal", 3'd0, 2'd2);

    // R8/R9 out-of-range readback and query
    see_read("R8 oob set", 3'd6, 2'd0, 32'd0);
    see_read("R8 oob way", 3'd0, 2'd3, 32'd0);
    see_victim("R9 oob query", 3'd7, 2'd0);

    // R2: second reset clears everything
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    clear_mdl();
    chk("R2 err cleared", 32'(err_flag), 0);
    sweep("R2 entries cleared");
    see_victim("R2 victim set0", 3'd0, 2'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule